// File: doc/BRIEF.md
# Chained Three-Input Lookup Logic Array

A small fabric of configurable logic cells that firmware programs through a plain register write port. Each cell reads three signals and uses them to index an 8-entry truth table. Two of the signals come from selectors: selector A picks from external pins or from the synchronised output of any cell, its own included. Selector B picks from a separate set of pins and peripheral events. The third signal is a carry, which is hard-wired to the combinational table output of the cell before it. Because of this fixed link, neighbouring cells can form wider functions without spending a selector.

The table result goes to the cell's pin output. It goes either directly or through a per-cell D flip-flop. The flip-flop captures on every system clock edge, or only after a rising edge of selector A, the carry, or the timer overflow input. The pin output then passes through a chain of system-clock registers before it is fed back or used internally. Rising and falling edges of the synchronised value can each set a sticky interrupt flag. Writing ones to a clear address clears the flags.

Top module: `clu_fabric`

## Requirements
- R1: While reset is low and at its release, every table, configuration field, flip-flop, synchroniser stage and flag is zero, so `pin_out`, `sync_out` and `irq_flags` are all zero.
- R2: A cell's table output is bit `{A, B, carry}` of its 8-bit table (A is index bit 2, carry is index bit 0). Table 0xC0 yields A AND B and table 0x3C yields A XOR B, whatever the carry.
- R3: The carry of cell n is the combinational table output of cell n-1, with no register in between. The carry of cell 0 is constant 0.
- R4: A-select code k < NPIN_A takes `pin_a[k]`. Code NPIN_A+j takes `sync_out[j]` for any cell j, including the cell itself. Larger codes give 0. B-select code k < NPIN_B takes `pin_b[k]`, and larger codes give 0.
- R5: With the bypass field set, `pin_out[i]` follows the cell's combinational table output in the same cycle.
- R6: With bypass clear and clock source 0 (system clock), `pin_out[i]` is the table output captured at every clock edge.
- R7: With bypass clear and clock source 1 (selector A), 2 (carry) or 3 (`tmr_ovf`), the flip-flop captures only at an edge where the chosen source is 1 and was 0 at the previous edge. Otherwise it holds.
- R8: `sync_out[i]` equals `pin_out[i]` delayed by SYNC_STAGES system clock edges.
- R9: When its enable is set, a 0-to-1 change of `sync_out[i]` sets `irq_flags[2i]` one edge later. A 1-to-0 change sets `irq_flags[2i+1]` one edge later. Flags stay set until cleared.
- R10: A write to address 2*NCELL clears every flag whose data bit is 1. A flag being set in the same cycle wins over the clear.
- R11: Address 2i writes cell i's table from data bits 7:0. Address 2i+1 writes its configuration. With the default parameters the configuration fields are: A-select in bits 3:0, B-select in bits 6:4, bypass in bit 7, clock source in bits 9:8, rise enable in bit 10 and fall enable in bit 11. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | DATA_W | Register write data |
| pin_a | input | NPIN_A | Sources for selector A |
| pin_b | input | NPIN_B | Sources for selector B |
| tmr_ovf | input | 1 | Timer overflow, usable as flip-flop clock event |
| pin_out | output | NCELL | Per-cell output after the optional flip-flop |
| sync_out | output | NCELL | Per-cell output after the synchroniser |
| irq_flags | output | 2*NCELL | Sticky edge flags, bit 2i rise and bit 2i+1 fall of cell i |

## Verification
The bench builds the fabric with four cells, eight A pins, six B pins and a two-stage synchroniser. With these values the 4-bit A code has four unused values (12 to 15) and the 3-bit B code has two (6 and 7), so the out-of-range zero rule is reached by random configuration writes. The short synchroniser keeps feedback loops through `sync_out` fast enough to oscillate and set flags many times within a few thousand cycles. Random writes also land on the seven unused addresses above the clear address.

// File: rtl/clu_pkg.sv
package clu_pkg;

   localparam int unsigned LUT_W = 8;

   typedef enum logic [1:0] {
      CK_SYS   = 2'd0,
      CK_SELA  = 2'd1,
      CK_CARRY = 2'd2,
      CK_TMR   = 2'd3
   } clk_src_e;

   function automatic int unsigned sel_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/clu_regs.sv
module clu_regs
   import clu_pkg::*;
#(
   parameter int unsigned NCELL  = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned AW     = 4,
   parameter int unsigned ASW    = 4,
   parameter int unsigned BSW    = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [AW-1:0]                   wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic [NCELL-1:0]                rise_evt,
   input  logic [NCELL-1:0]                fall_evt,
   output logic [NCELL-1:0][LUT_W-1:0]     lut_q,
   output logic [NCELL-1:0][ASW-1:0]       asel_q,
   output logic [NCELL-1:0][BSW-1:0]       bsel_q,
   output logic [NCELL-1:0]                bypass_q,
   output logic [NCELL-1:0][1:0]           clksel_q,
   output logic [NCELL-1:0]                rise_en_q,
   output logic [NCELL-1:0]                fall_en_q,
   output logic [2*NCELL-1:0]              flags_q
);

   localparam int unsigned BSEL_LO = ASW;
   localparam int unsigned BYP_BIT = ASW + BSW;
   localparam int unsigned CKS_LO  = BYP_BIT + 1;
   localparam int unsigned RIE_BIT = CKS_LO + 2;
   localparam int unsigned FIE_BIT = RIE_BIT + 1;
   localparam logic [AW-1:0] CLR_ADDR = AW'(2 * NCELL);

   for (genvar i = 0; i < NCELL; i++) begin : g_cell_regs
      localparam logic [AW-1:0] LUT_ADDR = AW'(2 * i);
      localparam logic [AW-1:0] CFG_ADDR = AW'(2 * i + 1);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lut_q[i] <= '0;
         end else if (wr_en && wr_addr == LUT_ADDR) begin
            lut_q[i] <= wr_data[LUT_W-1:0];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            asel_q[i]    <= '0;
            bsel_q[i]    <= '0;
            bypass_q[i]  <= 1'b0;
            clksel_q[i]  <= 2'd0;
            rise_en_q[i] <= 1'b0;
            fall_en_q[i] <= 1'b0;
         end else if (wr_en && wr_addr == CFG_ADDR) begin
            asel_q[i]    <= wr_data[ASW-1:0];
            bsel_q[i]    <= wr_data[BSEL_LO +: BSW];
            bypass_q[i]  <= wr_data[BYP_BIT];
            clksel_q[i]  <= wr_data[CKS_LO +: 2];
            rise_en_q[i] <= wr_data[RIE_BIT];
            fall_en_q[i] <= wr_data[FIE_BIT];
         end
      end
   end

   logic [2*NCELL-1:0] flag_set;
   logic [2*NCELL-1:0] flag_clr;

   always_comb begin
      for (int i = 0; i < NCELL; i++) begin
         flag_set[2*i]   = rise_evt[i] & rise_en_q[i];
         flag_set[2*i+1] = fall_evt[i] & fall_en_q[i];
      end
      flag_clr = (wr_en && wr_addr == CLR_ADDR) ? wr_data[2*NCELL-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         flags_q <= (flags_q & ~flag_clr) | flag_set;
      end
   end

endmodule

// File: rtl/clu_cell.sv
module clu_cell
   import clu_pkg::*;
#(
   parameter int unsigned NA_TOT      = 12,
   parameter int unsigned NB          = 8,
   parameter int unsigned ASW         = 4,
   parameter int unsigned BSW         = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LUT_W-1:0]  lut,
   input  logic [ASW-1:0]    asel,
   input  logic [BSW-1:0]    bsel,
   input  logic              bypass,
   input  logic [1:0]        clksel,
   input  logic [NA_TOT-1:0] a_src,
   input  logic [NB-1:0]     b_src,
   input  logic              carry_in,
   input  logic              tmr_ovf,
   output logic              lut_out,
   output logic              pin_out,
   output logic              sync_out,
   output logic              rise_evt,
   output logic              fall_evt
);

   logic     a_val, b_val;
   logic     a_prev, c_prev, t_prev;
   logic     capture;
   logic     ff_q;
   logic     sync_prev;
   clk_src_e src;

   always_comb begin
      a_val = 1'b0;
      if (int'(asel) < NA_TOT) a_val = a_src[asel];
      b_val = 1'b0;
      if (int'(bsel) < NB) b_val = b_src[bsel];
   end

   assign lut_out = lut[{a_val, b_val, carry_in}];
   assign src     = clk_src_e'(clksel);

   always_comb begin
      unique case (src)
         CK_SYS:   capture = 1'b1;
         CK_SELA:  capture = a_val & ~a_prev;
         CK_CARRY: capture = carry_in & ~c_prev;
         CK_TMR:   capture = tmr_ovf & ~t_prev;
         default:  capture = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_prev <= 1'b0;
         c_prev <= 1'b0;
         t_prev <= 1'b0;
         ff_q   <= 1'b0;
      end else begin
         a_prev <= a_val;
         c_prev <= carry_in;
         t_prev <= tmr_ovf;
         if (capture) ff_q <= lut_out;
      end
   end

   assign pin_out = bypass ? lut_out : ff_q;

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
         if (!rst_n) sync_out <= 1'b0;
         else        sync_out <= pin_out;
      end
   end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] stg;
      always_ff @(posedge clk) begin
         if (!rst_n) stg <= '0;
         else        stg <= {stg[SYNC_STAGES-2:0], pin_out};
      end
      assign sync_out = stg[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sync_prev <= 1'b0;
      else        sync_prev <= sync_out;
   end

   assign rise_evt = sync_out & ~sync_prev;
   assign fall_evt = ~sync_out & sync_prev;

endmodule

// File: rtl/clu_fabric.sv
module clu_fabric
   import clu_pkg::*;
#(
   parameter int unsigned NCELL       = 4,
   parameter int unsigned NPIN_A      = 8,
   parameter int unsigned NPIN_B      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 16,
   localparam int unsigned NA_TOT     = NPIN_A + NCELL,
   localparam int unsigned ASW        = sel_bits(NA_TOT),
   localparam int unsigned BSW        = sel_bits(NPIN_B),
   localparam int unsigned AW         = sel_bits(2 * NCELL + 1),
   localparam int unsigned CFG_W      = ASW + BSW + 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [NPIN_A-1:0]  pin_a,
   input  logic [NPIN_B-1:0]  pin_b,
   input  logic               tmr_ovf,
   output logic [NCELL-1:0]   pin_out,
   output logic [NCELL-1:0]   sync_out,
   output logic [2*NCELL-1:0] irq_flags
);

   if (NCELL < 1)            begin : g_bad_cells $error("NCELL must be at least 1"); end
   if (NPIN_A < 1)           begin : g_bad_pa    $error("NPIN_A must be at least 1"); end
   if (NPIN_B < 1)           begin : g_bad_pb    $error("NPIN_B must be at least 1"); end
   if (SYNC_STAGES < 1)      begin : g_bad_sync  $error("SYNC_STAGES must be at least 1"); end
   if (DATA_W < CFG_W)       begin : g_bad_cfgw  $error("DATA_W too narrow for config"); end
   if (DATA_W < LUT_W)       begin : g_bad_lutw  $error("DATA_W too narrow for table"); end
   if (DATA_W < 2 * NCELL)   begin : g_bad_clrw  $error("DATA_W too narrow for flag clear"); end

   logic [NCELL-1:0][LUT_W-1:0] lut_q;
   logic [NCELL-1:0][ASW-1:0]   asel_q;
   logic [NCELL-1:0][BSW-1:0]   bsel_q;
   logic [NCELL-1:0]            bypass_q;
   logic [NCELL-1:0][1:0]       clksel_q;
   logic [NCELL-1:0]            rise_en_q;
   logic [NCELL-1:0]            fall_en_q;
   logic [NCELL-1:0]            rise_evt, fall_evt;
   logic [NCELL-1:0]            lut_out;
   logic [NCELL-1:0]            carry;
   logic [NA_TOT-1:0]           a_src;

   clu_regs #(
      .NCELL (NCELL), .DATA_W(DATA_W), .AW(AW), .ASW(ASW), .BSW(BSW)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .lut_q    (lut_q),
      .asel_q   (asel_q),
      .bsel_q   (bsel_q),
      .bypass_q (bypass_q),
      .clksel_q (clksel_q),
      .rise_en_q(rise_en_q),
      .fall_en_q(fall_en_q),
      .flags_q  (irq_flags)
   );

   assign a_src = {sync_out, pin_a};

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      if (i == 0) begin : g_head
         assign carry[i] = 1'b0;
      end else begin : g_link
         assign carry[i] = lut_out[i-1];
      end

      clu_cell #(
         .NA_TOT(NA_TOT), .NB(NPIN_B), .ASW(ASW), .BSW(BSW),
         .SYNC_STAGES(SYNC_STAGES)
      ) i_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .lut     (lut_q[i]),
         .asel    (asel_q[i]),
         .bsel    (bsel_q[i]),
         .bypass  (bypass_q[i]),
         .clksel  (clksel_q[i]),
         .a_src   (a_src),
         .b_src   (pin_b),
         .carry_in(carry[i]),
         .tmr_ovf (tmr_ovf),
         .lut_out (lut_out[i]),
         .pin_out (pin_out[i]),
         .sync_out(sync_out[i]),
         .rise_evt(rise_evt[i]),
         .fall_evt(fall_evt[i])
      );
   end

endmodule

// File: rtl/clu_fabric_chk.sv
module clu_fabric_chk #(
   parameter int unsigned NCELL       = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned AW          = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [AW-1:0]      wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic               tmr_ovf,
   input logic [NCELL-1:0]   pin_out,
   input logic [NCELL-1:0]   sync_out,
   input logic [2*NCELL-1:0] irq_flags,
   input logic [NCELL-1:0]   bypass_q,
   input logic [NCELL-1:0][1:0] clksel_q,
   input logic [NCELL-1:0]   rise_en_q,
   input logic [NCELL-1:0]   fall_en_q
);

   localparam logic [AW-1:0] CLR_ADDR = AW'(2 * NCELL);

   logic [3:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
   end

   a_r1_reset_outputs: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_out == '0 && sync_out == '0 && irq_flags == '0));

   for (genvar i = 0; i < NCELL; i++) begin : g_chk
      logic clr_rise, clr_fall;
      assign clr_rise = wr_en && wr_addr == CLR_ADDR && wr_data[2*i];
      assign clr_fall = wr_en && wr_addr == CLR_ADDR && wr_data[2*i+1];

      a_r7_tmr_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (!wr_en && !bypass_q[i] && clksel_q[i] == 2'd3 && !tmr_ovf)
         |=> $stable(pin_out[i]));

      a_r9_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (rise_en_q[i] && $rose(sync_out[i])) |=> irq_flags[2*i]);

      a_r9_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
         (fall_en_q[i] && $fell(sync_out[i])) |=> irq_flags[2*i+1]);

      a_r9_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_flags[2*i] && !clr_rise) |=> irq_flags[2*i]);

      a_r10_clear_rise: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_rise && !(rise_en_q[i] && $rose(sync_out[i]))) |=> !irq_flags[2*i]);

      a_r10_clear_fall: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_fall && !(fall_en_q[i] && $fell(sync_out[i]))) |=> !irq_flags[2*i+1]);

      if (SYNC_STAGES <= 4) begin : g_sync_chk
         a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 4'(SYNC_STAGES)) |-> sync_out[i] == $past(pin_out[i], SYNC_STAGES));
      end
   end

endmodule

bind clu_fabric clu_fabric_chk #(
   .NCELL(NCELL), .DATA_W(DATA_W), .AW(AW), .SYNC_STAGES(SYNC_STAGES)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .tmr_ovf  (tmr_ovf),
   .pin_out  (pin_out),
   .sync_out (sync_out),
   .irq_flags(irq_flags),
   .bypass_q (bypass_q),
   .clksel_q (clksel_q),
   .rise_en_q(rise_en_q),
   .fall_en_q(fall_en_q)
);

// File: tb/test_clu_fabric.sv
`timescale 1ns/1ps
module test_clu_fabric;

   localparam int NC = 4;
   localparam int NA = 8;
   localparam int NB = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [NA-1:0] pa = '0;
   logic [NB-1:0] pb = '0;
   logic        tmr = 1'b0;
   logic [NC-1:0]   pin_out, sync_out;
   logic [2*NC-1:0] irq_flags;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   clu_fabric #(.NCELL(NC), .NPIN_A(NA), .NPIN_B(NB), .SYNC_STAGES(2), .DATA_W(16)) i_clu_fabric (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pin_a(pa), .pin_b(pb), .tmr_ovf(tmr),
      .pin_out(pin_out), .sync_out(sync_out), .irq_flags(irq_flags)
   );

   // reference model state
   logic [7:0]  m_lut [NC];
   logic [15:0] m_cfg [NC];
   logic [NC-1:0] m_ff, m_s0, m_s1, m_sp, m_ap, m_cp, m_tp;
   logic [2*NC-1:0] m_fl;
   logic [NC-1:0] e_lut, e_a, e_c, e_pin;

   function automatic void model_reset();
      for (int i = 0; i < NC; i++) begin
         m_lut[i] = '0;
         m_cfg[i] = '0;
      end
      m_ff = '0; m_s0 = '0; m_s1 = '0; m_sp = '0;
      m_ap = '0; m_cp = '0; m_tp = '0; m_fl = '0;
   endfunction

   function automatic void comb_eval();
      for (int i = 0; i < NC; i++) begin
         int as, bs;
         logic a, b, c;
         as = int'(m_cfg[i][3:0]);
         bs = int'(m_cfg[i][6:4]);
         if (as < NA)           a = pa[as];
         else if (as < NA + NC) a = m_s1[as-NA];
         else                   a = 1'b0;
         b = (bs < NB) ? pb[bs] : 1'b0;
         c = (i == 0) ? 1'b0 : e_lut[i-1];
         e_a[i] = a;
         e_c[i] = c;
         e_lut[i] = m_lut[i][{a, b, c}];
         e_pin[i] = m_cfg[i][7] ? e_lut[i] : m_ff[i];
      end
   endfunction

   function automatic void model_edge();
      logic [2*NC-1:0] set, clr;
      comb_eval();
      set = '0;
      clr = (wr_en && wr_addr == 4'(2*NC)) ? wr_data[2*NC-1:0] : '0;
      for (int i = 0; i < NC; i++) begin
         logic cap;
         case (m_cfg[i][9:8])
            2'd0: cap = 1'b1;
            2'd1: cap = e_a[i] & ~m_ap[i];
            2'd2: cap = e_c[i] & ~m_cp[i];
            default: cap = tmr & ~m_tp[i];
         endcase
         set[2*i]   = m_cfg[i][10] & m_s1[i] & ~m_sp[i];
         set[2*i+1] = m_cfg[i][11] & ~m_s1[i] & m_sp[i];
         if (cap) m_ff[i] = e_lut[i];
         m_ap[i] = e_a[i];
         m_cp[i] = e_c[i];
         m_tp[i] = tmr;
         m_sp[i] = m_s1[i];
         m_s1[i] = m_s0[i];
         m_s0[i] = e_pin[i];
      end
      m_fl = (m_fl & ~clr) | set;
      if (wr_en && wr_addr < 4'(2*NC)) begin
         if (wr_addr[0]) m_cfg[wr_addr >> 1] = wr_data;
         else            m_lut[wr_addr >> 1] = wr_data[7:0];
      end
   endfunction

   task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      comb_eval();
      checks += 3;
      if (pin_out !== e_pin) begin
         fails++;
         $display("FAIL %s pin_out actual=%b expected=%b", tag, pin_out, e_pin);
      end
      if (sync_out !== m_s1) begin
         fails++;
         $display("FAIL R8 (%s) sync_out actual=%b expected=%b", tag, sync_out, m_s1);
      end
      if (irq_flags !== m_fl) begin
         fails++;
         $display("FAIL R9 (%s) irq_flags actual=%b expected=%b", tag, irq_flags, m_fl);
      end
   endtask

   task automatic step(input string tag);
      model_edge();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(tag);
      wr_en = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired before completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_C10F));
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check_bit("R1", "pin_out zero", |pin_out, 1'b0);
      check_bit("R1", "sync_out zero", |sync_out, 1'b0);
      check_bit("R1", "irq_flags zero", |irq_flags, 1'b0);
      rst_n = 1'b1;
      step("R1");

      // R2: AND table on cell 0, bypassed, A=pa[0], B=pb[0]
      wr(4'd0, 16'h00C0, "R11");
      wr(4'd1, 16'h0080, "R11");
      for (int k = 0; k < 4; k++) begin
         pa[0] = k[1]; pb[0] = k[0];
         step("R2");
         check_bit("R2", "AND output", pin_out[0], k[1] & k[0]);
      end
      // R3: cell 1 table 0xAA outputs its carry
      wr(4'd2, 16'h00AA, "R11");
      wr(4'd3, 16'h0080, "R11");
      for (int k = 0; k < 4; k++) begin
         pa[0] = k[1]; pb[0] = k[0];
         step("R3");
         check_bit("R3", "carry follows previous cell", pin_out[1], k[1] & k[0]);
      end
      // R3: carry into cell 0 is 0 (table 0x55 = NOT carry)
      wr(4'd0, 16'h0055, "R3");
      check_bit("R3", "cell0 carry is zero", pin_out[0], 1'b1);
      // R2: XOR on cell 1 with carry forced to 1 by cell 0 table 0xFF
      wr(4'd0, 16'h00FF, "R2");
      wr(4'd2, 16'h003C, "R2");
      for (int k = 0; k < 4; k++) begin
         pa[0] = k[1]; pb[0] = k[0];
         step("R2");
         check_bit("R2", "XOR with carry=1", pin_out[1], k[1] ^ k[0]);
      end
      // R5: bypass follows same cycle
      pa[0] = 1'b1; pb[0] = 1'b0; #1;
      check_bit("R5", "bypassed output combinational", pin_out[1], 1'b1);
      // R6: system-clocked flip-flop, one edge later
      wr(4'd3, 16'h0000, "R6");
      pa[0] = 1'b0; #1;
      check_bit("R6", "flip-flop holds before edge", pin_out[1], 1'b1);
      step("R6");
      check_bit("R6", "flip-flop captures at edge", pin_out[1], 1'b0);

      // R4: cell 2 inverts its own synchronised output, flags on both edges
      wr(4'd4, 16'h000F, "R4");
      wr(4'd5, 16'h0C00 | 16'd10, "R4");
      repeat (20) step("R4");
      check_bit("R9", "rise flag of cell 2", irq_flags[4], 1'b1);
      check_bit("R9", "fall flag of cell 2", irq_flags[5], 1'b1);
      // R10: clear flags of cell 2 while it keeps toggling
      wr(4'd5, 16'd10, "R10");
      repeat (4) step("R10");
      wr(4'd8, 16'h00FF, "R10");
      check_bit("R10", "flags cleared", irq_flags[5:4] == 2'b00, 1'b1);
      // R4: out-of-range A code gives 0 (table 0x0F = NOT A)
      wr(4'd5, 16'd14, "R4");
      repeat (3) step("R4");
      check_bit("R4", "out-of-range A reads 0", pin_out[2], 1'b1);

      // R7: cell 3 captures A only on timer overflow rising edge
      wr(4'd6, 16'h00F0, "R7");
      wr(4'd7, 16'h0300, "R7");
      pa[0] = 1'b1;
      repeat (3) step("R7");
      check_bit("R7", "holds without timer edge", pin_out[3], 1'b0);
      tmr = 1'b1;
      step("R7");
      check_bit("R7", "captures on timer edge", pin_out[3], 1'b1);
      pa[0] = 1'b0;
      repeat (3) step("R7");
      check_bit("R7", "level high timer is not an edge", pin_out[3], 1'b1);
      tmr = 1'b0;

      // R11: writes to unused addresses change nothing
      for (int a = 2*NC + 1; a < 16; a++) wr(4'(a), 16'hFFFF, "R11");
      repeat (4) step("R11");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         pa  = NA'($urandom);
         pb  = NB'($urandom);
         tmr = ($urandom % 4) == 0;
         if (($urandom % 5) == 0) wr(4'($urandom), 16'($urandom), "R4/R5/R6/R7/R11");
         else                     step("R2/R3/R4/R5/R6/R7");
      end

      summary();
      $finish;
   end

endmodule